// File: doc/BRIEF.md
# Modem Transmit Clock Generator

This block makes the transmit bit clock for the serial data port of a voiceband modem. It runs on a fixed 11.0592 MHz system clock. A single counter divides that clock down. In synchronous PSK mode the output is a 1200 Hz bit clock. It can run free, or it can be phase-locked to an external clock pin or to the recovered receive clock. In the FSK modes the same counter instead produces a clock at sixteen times the baud rate, which is meant to drive a UART.

The lock is digital. Each detected rising edge of the selected reference is compared with the counter position. The divider period then in progress is stretched or trimmed by one system-clock count. A new mode or source is loaded only when the counter rolls over, so the output never emits a short pulse. In PSK mode the block also registers the serial transmit bit on each rising edge of the transmit clock.

Top module: `modem_txclk_gen`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears the counter, drives txclk low and txd_smp high, and makes internal-source PSK the active setting whatever mode_sel and src_sel hold. The first rising edge of txclk therefore comes DIV_PSK/2 system clocks after reset is released.
- R2: In PSK mode with the internal source, txclk has a period of exactly DIV_PSK system clocks (default 9216, which gives 1200 Hz). It is high for DIV_PSK/2 of them.
- R3: mode_sel picks the divide ratio, and each FSK clock is high for half its period:
  - 00: PSK, DIV_PSK.
  - 01: V.23 forward channel, DIV_V23_FWD (default 576, which gives 16 x 1200 Hz).
  - 10: V.23 backward channel, DIV_V23_BACK (default 9216, which gives 16 x 75 Hz).
  - 11: V.21, DIV_V21 (default 2304, which gives 16 x 300 Hz).
- R4: src_sel chooses the PSK reference: 00 internal, 01 ext_clk, 10 rx_clk, 11 internal. In the FSK modes both reference inputs are ignored.
- R5: While locking, each detected reference rising edge adjusts the period in progress by at most one count:
  - Counter at 0 when the edge is detected: no change.
  - Counter below half: one count longer.
  - Counter at half or above: one count shorter.
  - Every locked period therefore lies between DIV_PSK-1 and DIV_PSK+1.
- R6: With a reference whose period is within one count of DIV_PSK, txclk settles to the reference period. With a reference of period exactly DIV_PSK, the delay from a reference rising edge to the next txclk falling edge also settles to a constant.
- R7: A change of mode_sel or src_sel takes effect only at the next counter rollover. The pulse in progress completes at its old length, and the next one starts at the new length.
- R8: txclk keeps toggling in every mode and every source setting.
- R9: In PSK mode txd_smp takes txd in the system clock edge at which txclk rises, and holds between rises.
- R10: In the FSK modes txd_smp follows txd one system clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 11.0592 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Requested mode: 00 PSK, 01 V.23 fwd, 10 V.23 back, 11 V.21 |
| src_sel | input | 2 | Requested PSK clock source: 00/11 internal, 01 external, 10 receive |
| ext_clk | input | 1 | External reference clock, asynchronous |
| rx_clk | input | 1 | Recovered receive clock, asynchronous |
| txd | input | 1 | Serial transmit data in |
| txclk | output | 1 | Transmit clock |
| txd_smp | output | 1 | Transmit data registered on the txclk rise (PSK) or each clock (FSK) |

## Verification
The bench targets the following corner cases:
- Mode change in the middle of a high phase. A design that switched at once would cut the pulse; the bench expects a full old-length high time followed by a mixed rise-to-rise interval.
- Reset while a V.21 request is held. A design that loaded the request during reset would rise after a quarter of the expected time.
- Lock to an external clock of exactly the nominal period, starting from an arbitrary phase. A design whose correction had the wrong sign or no clamp would drift, or produce periods outside nominal plus or minus one.
- Lock to a receive clock one count fast. The period must settle to that rate.
- Reference edges fed during FSK modes. These must not disturb the FSK period.
- A data bit changed just after a txclk rise. It must not appear on txd_smp before the next rise.

// File: rtl/txg_pkg.sv
// Package txg_pkg
// Shared types for the transmit clock generator: mode and source codes,
// the active configuration record and the one-count period adjustment.
package txg_pkg;

    typedef enum logic [1:0] {
        MODE_PSK      = 2'b00,
        MODE_V23_FWD  = 2'b01,
        MODE_V23_BACK = 2'b10,
        MODE_V21      = 2'b11
    } txg_mode_e;

    typedef enum logic [1:0] {
        SRC_INT = 2'b00,
        SRC_EXT = 2'b01,
        SRC_RX  = 2'b10,
        SRC_ALT = 2'b11
    } txg_src_e;

    typedef struct packed {
        txg_mode_e mode;
        txg_src_e  src;
    } txg_cfg_t;

    typedef enum logic [1:0] {
        ADJ_NONE  = 2'b00,
        ADJ_LONG  = 2'b01,
        ADJ_SHORT = 2'b10
    } txg_adj_e;

endpackage

// File: rtl/txg_ref_edge.sv
// Module txg_ref_edge
// Brings one asynchronous reference clock into the system clock domain
// through a chain of STAGES flops and flags its rising edge for one cycle.
// Assumes the reference stays high and low for several system clocks.
module txg_ref_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic rise_o
);

    logic [STAGES:0] pipe_q;

    // Shift the reference through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], ref_in};
        end
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // A synchronised edge can never be flagged on two cycles in a row.
    assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/txg_phase_det.sv
// Module txg_phase_det
// Compares each reference rising edge with the divider count and asks the
// divider for one count more or less in the period in progress.
// Assumes the divider consumes a request at its next rollover.
module txg_phase_det
    import txg_pkg::*;
#(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_en,
    input  logic          ref_rise,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] half,
    input  logic          roll,
    output txg_adj_e      adj_o
);

    txg_adj_e decide;
    txg_adj_e adj_q;
    logic     hit;

    assign hit = lock_en && ref_rise;

    // Classify the counter position seen at the reference edge.
    always_comb begin
        if (cnt == '0) begin
            decide = ADJ_NONE;
        end else if (cnt < half) begin
            decide = ADJ_LONG;
        end else begin
            decide = ADJ_SHORT;
        end
    end

    // Keep a request until the rollover that applies it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_q <= ADJ_NONE;
        end else if (roll) begin
            adj_q <= ADJ_NONE;
        end else if (hit) begin
            adj_q <= decide;
        end
    end

    assign adj_o = hit ? decide : adj_q;

endmodule

// File: rtl/txg_div.sv
// Module txg_div
// Programmable divider that builds the transmit clock. The active mode picks
// the base period; an adjustment request stretches or trims the current
// period by one count. A requested configuration is loaded only at rollover.
// Assumes every divide ratio is at least 4.
module txg_div
    import txg_pkg::*;
#(
    parameter int CW           = 14,
    parameter int DIV_PSK      = 9216,
    parameter int DIV_V23_FWD  = 576,
    parameter int DIV_V23_BACK = 9216,
    parameter int DIV_V21      = 2304,
    parameter int DIV_MAX      = 9216
) (
    input  logic          clk,
    input  logic          rst_n,
    input  txg_cfg_t      cfg_req,
    input  txg_adj_e      adj,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] half_o,
    output logic          roll_o,
    output txg_cfg_t      cfg_o,
    output logic          txclk_o,
    output logic          rise_next_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] base;
    logic [CW-1:0] term;
    logic [CW-1:0] half;
    logic          roll;
    logic          txclk_q;
    txg_cfg_t      cfg_q;

    // Base period for the mode now active.
    always_comb begin
        case (cfg_q.mode)
            MODE_V23_FWD:  base = CW'(DIV_V23_FWD);
            MODE_V23_BACK: base = CW'(DIV_V23_BACK);
            MODE_V21:      base = CW'(DIV_V21);
            default:       base = CW'(DIV_PSK);
        endcase
    end

    // Terminal count after the one-count adjustment.
    always_comb begin
        case (adj)
            ADJ_LONG:  term = base;
            ADJ_SHORT: term = base - CW'(2);
            default:   term = base - CW'(1);
        endcase
    end

    assign half  = base >> 1;
    assign roll  = (cnt_q >= term);
    assign cnt_d = roll ? '0 : cnt_q + CW'(1);

    // Advance the counter, shape the clock, load new settings at rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            txclk_q <= 1'b0;
            cfg_q   <= '{mode: MODE_PSK, src: SRC_INT};
        end else begin
            cnt_q   <= cnt_d;
            txclk_q <= !roll && (cnt_d >= half);
            if (roll) begin
                cfg_q <= cfg_req;
            end
        end
    end

    assign cnt_o       = cnt_q;
    assign half_o      = half;
    assign roll_o      = roll;
    assign cfg_o       = cfg_q;
    assign txclk_o     = txclk_q;
    assign rise_next_o = !roll && (cnt_d == half);

    // The clock is low in the cycle after every rollover.
    assert_roll_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> !txclk_q);

    // Settings change only at rollover.
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !roll |=> $stable(cfg_q));

    // An adjusted period never runs past the longest base plus one count.
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DIV_MAX));

endmodule

// File: rtl/txg_data_smp.sv
// Module txg_data_smp
// Registers the serial transmit bit: on the txclk rise in PSK mode, and on
// every system clock in the FSK modes. Output idles at mark (1) after reset.
module txg_data_smp (
    input  logic clk,
    input  logic rst_n,
    input  logic psk_act,
    input  logic rise_next,
    input  logic txd,
    output logic txd_smp_o
);

    logic txd_q;

    // Take the data bit when the active mode calls for it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd_q <= 1'b1;
        end else if (!psk_act || rise_next) begin
            txd_q <= txd;
        end
    end

    assign txd_smp_o = txd_q;

    // In PSK mode the bit changes only together with a txclk rise.
    assert_txd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (psk_act && !rise_next) |=> $stable(txd_q));

endmodule

// File: rtl/modem_txclk_gen.sv
// Module modem_txclk_gen
// Top level of the transmit clock generator. Synchronises both reference
// clocks, selects the one the active source asks for, and feeds its edges
// to the phase detector that steers the divider. Assumes clk is the
// 11.0592 MHz system clock and that references are much slower than clk.
module modem_txclk_gen
    import txg_pkg::*;
#(
    parameter int DIV_PSK      = 9216,
    parameter int DIV_V23_FWD  = 576,
    parameter int DIV_V23_BACK = 9216,
    parameter int DIV_V21      = 2304,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic [1:0] src_sel,
    input  logic       ext_clk,
    input  logic       rx_clk,
    input  logic       txd,
    output logic       txclk,
    output logic       txd_smp
);

    localparam int MAX_A   = (DIV_PSK > DIV_V23_FWD) ? DIV_PSK : DIV_V23_FWD;
    localparam int MAX_B   = (DIV_V23_BACK > DIV_V21) ? DIV_V23_BACK : DIV_V21;
    localparam int DIV_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(DIV_MAX + 2);
    localparam int N_REF   = 2;

    txg_cfg_t      cfg_req;
    txg_cfg_t      cfg_act;
    txg_adj_e      adj;
    logic [CW-1:0] cnt;
    logic [CW-1:0] half;
    logic          roll;
    logic          rise_next;
    logic          lock_en;
    logic          ref_sel_rise;
    logic [N_REF-1:0] ref_in;
    logic [N_REF-1:0] ref_rise;

    assign cfg_req = '{mode: txg_mode_e'(mode_sel), src: txg_src_e'(src_sel)};
    assign ref_in  = {rx_clk, ext_clk};

    // One synchroniser and edge detector per reference input.
    for (genvar g = 0; g < N_REF; g++) begin : g_ref
        txg_ref_edge #(.STAGES(SYNC_STAGES)) i_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .ref_in (ref_in[g]),
            .rise_o (ref_rise[g])
        );
    end

    // Lock only in PSK mode with an external or receive source.
    always_comb begin
        lock_en      = 1'b0;
        ref_sel_rise = 1'b0;
        if (cfg_act.mode == MODE_PSK) begin
            case (cfg_act.src)
                SRC_EXT: begin lock_en = 1'b1; ref_sel_rise = ref_rise[0]; end
                SRC_RX:  begin lock_en = 1'b1; ref_sel_rise = ref_rise[1]; end
                default: begin lock_en = 1'b0; ref_sel_rise = 1'b0; end
            endcase
        end
    end

    txg_phase_det #(.CW(CW)) i_pd (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_en  (lock_en),
        .ref_rise (ref_sel_rise),
        .cnt      (cnt),
        .half     (half),
        .roll     (roll),
        .adj_o    (adj)
    );

    txg_div #(
        .CW           (CW),
        .DIV_PSK      (DIV_PSK),
        .DIV_V23_FWD  (DIV_V23_FWD),
        .DIV_V23_BACK (DIV_V23_BACK),
        .DIV_V21      (DIV_V21),
        .DIV_MAX      (DIV_MAX)
    ) i_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_req     (cfg_req),
        .adj         (adj),
        .cnt_o       (cnt),
        .half_o      (half),
        .roll_o      (roll),
        .cfg_o       (cfg_act),
        .txclk_o     (txclk),
        .rise_next_o (rise_next)
    );

    txg_data_smp i_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .psk_act   (cfg_act.mode == MODE_PSK),
        .rise_next (rise_next),
        .txd       (txd),
        .txd_smp_o (txd_smp)
    );

    // FSK modes never receive a period adjustment from the reference path.
    assert_fsk_no_adj_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_act.mode != MODE_PSK) |-> (adj == ADJ_NONE));

endmodule

// File: tb/test_modem_txclk_gen.sv
// Scoreboard bench: driver tasks queue expected txclk periods, high times
// and data bits; a monitor at the falling clock edge measures and compares.
module test_modem_txclk_gen;

    localparam int P_PSK  = 192;
    localparam int P_FWD  = 12;
    localparam int P_BACK = 192;
    localparam int P_V21  = 48;

    typedef struct {
        int    lo;
        int    hi;
        string tag;
    } rng_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b11;
    logic [1:0] src_sel = 2'b01;
    logic       ext_clk = 1'b0;
    logic       rx_clk = 1'b0;
    logic       txd = 1'b0;
    logic       txclk;
    logic       txd_smp;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int fall_cnt = 0;
    int ext_rise_cnt = 0;
    int last_rise = 0;
    int gap = 0;
    int max_gap = 0;
    int ext_hi = 35;
    int ext_lo = 35;
    bit have_rise = 0;
    bit last_tx = 0;
    rng_t pq[$];
    rng_t hq[$];
    bit   dq[$];
    rng_t r;
    bit   b;

    modem_txclk_gen #(
        .DIV_PSK      (P_PSK),
        .DIV_V23_FWD  (P_FWD),
        .DIV_V23_BACK (P_BACK),
        .DIV_V21      (P_V21)
    ) i_modem_txclk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .src_sel  (src_sel),
        .ext_clk  (ext_clk),
        .rx_clk   (rx_clk),
        .txd      (txd),
        .txclk    (txclk),
        .txd_smp  (txd_smp)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_per(input int n, input int lo, input int hi, input string tag);
        for (int i = 0; i < n; i++) pq.push_back('{lo, hi, tag});
    endtask

    task automatic push_high(input int n, input int v, input string tag);
        for (int i = 0; i < n; i++) hq.push_back('{v, v, tag});
    endtask

    task automatic wait_rises(input int n);
        int target;
        target = rise_cnt + n;
        wait (rise_cnt >= target);
    endtask

    task automatic drain();
        while (pq.size() != 0 || hq.size() != 0 || dq.size() != 0) @(negedge clk);
    endtask

    // External reference: free-running, half-periods set by the driver.
    initial begin
        forever begin
            repeat (ext_lo) @(negedge clk);
            ext_clk = 1'b1;
            ext_rise_cnt++;
            repeat (ext_hi) @(negedge clk);
            ext_clk = 1'b0;
        end
    end

    // Receive reference: period 191 system clocks.
    initial begin
        forever begin
            repeat (96) @(negedge clk);
            rx_clk = 1'b1;
            repeat (95) @(negedge clk);
            rx_clk = 1'b0;
        end
    end

    // Monitor: measure txclk intervals and compare against the queues.
    always @(negedge clk) begin
        if (!rst_n) begin
            have_rise = 0;
            last_tx   = 0;
            gap       = 0;
        end else begin
            gap++;
            if (txclk && !last_tx) begin
                if (have_rise && pq.size() > 0) begin
                    r = pq.pop_front();
                    chk((cyc - last_rise) >= r.lo && (cyc - last_rise) <= r.hi, r.tag,
                        $sformatf("rise-to-rise period (range %0d..%0d)", r.lo, r.hi),
                        cyc - last_rise, r.lo);
                end
                if (dq.size() > 0) begin
                    b = dq.pop_front();
                    chk(txd_smp == b, "R9", "txd_smp at txclk rise", int'(txd_smp), int'(b));
                end
                last_rise = cyc;
                have_rise = 1;
                gap = 0;
                rise_cnt++;
            end else if (!txclk && last_tx) begin
                if (hq.size() > 0) begin
                    r = hq.pop_front();
                    chk((cyc - last_rise) == r.lo, r.tag, "high time", cyc - last_rise, r.lo);
                end
                gap = 0;
                fall_cnt++;
            end
            if (gap > max_gap) max_gap = gap;
            last_tx = txclk;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int rel;
        int t0;
        int d0;
        int fc;
        bit prev;
        bit v;

        // R1: reset state while a V.21 request with external source is held.
        repeat (10) @(negedge clk);
        chk(txclk == 1'b0, "R1", "txclk in reset", int'(txclk), 0);
        chk(txd_smp == 1'b1, "R1", "txd_smp in reset", int'(txd_smp), 1);
        // R7: the first period runs as PSK, the switch to V.21 at rollover.
        push_per(1, 120, 120, "R7");
        push_per(6, P_V21, P_V21, "R3");
        push_high(1, P_PSK / 2, "R7");
        push_high(6, P_V21 / 2, "R4");
        rst_n = 1'b1;
        rel = cyc;
        wait (rise_cnt == 1);
        chk((cyc - rel) == P_PSK / 2, "R1", "first rise after reset", cyc - rel, P_PSK / 2);
        drain();

        // R3: V.23 forward channel.
        mode_sel = 2'b01;
        wait_rises(3);
        push_per(8, P_FWD, P_FWD, "R3");
        push_high(8, P_FWD / 2, "R3");
        drain();

        // R3: V.23 backward channel.
        mode_sel = 2'b10;
        wait_rises(3);
        push_per(4, P_BACK, P_BACK, "R3");
        push_high(4, P_BACK / 2, "R3");
        drain();

        // R2: internal PSK.
        mode_sel = 2'b00;
        src_sel  = 2'b00;
        wait_rises(3);
        push_per(4, P_PSK, P_PSK, "R2");
        push_high(4, P_PSK / 2, "R2");
        drain();

        // R7: request V.21 ten cycles into a PSK high phase.
        wait_rises(1);
        push_per(1, 120, 120, "R7");
        push_per(3, P_V21, P_V21, "R7");
        push_high(1, P_PSK / 2, "R7");
        push_high(3, P_V21 / 2, "R7");
        repeat (10) @(negedge clk);
        mode_sel = 2'b11;
        drain();

        // R10: FSK data path follows txd one clock later.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            txd = (i % 3 == 1) ? 1'b0 : ~txd;
            @(negedge clk);
            chk(txd_smp == txd, "R10", "txd_smp in FSK", int'(txd_smp), int'(txd));
        end

        // R9: PSK data capture at the txclk rise, hold in between.
        mode_sel = 2'b00;
        src_sel  = 2'b11;
        wait_rises(3);
        prev = txd_smp;
        for (int i = 0; i < 5; i++) begin
            v = (i % 2 == 0);
            repeat (2) @(negedge clk);
            txd = ~prev;
            repeat (98) @(negedge clk);
            chk(txd_smp == prev, "R9", "txd_smp held between rises", int'(txd_smp), int'(prev));
            repeat (50) @(negedge clk);
            txd = v;
            dq.push_back(v);
            wait_rises(1);
            prev = v;
        end
        drain();

        // R5/R6: lock to an external clock of exactly the nominal period.
        ext_hi  = P_PSK / 2;
        ext_lo  = P_PSK / 2;
        src_sel = 2'b01;
        wait_rises(1);
        push_per(110, P_PSK - 1, P_PSK + 1, "R5");
        push_per(8, P_PSK, P_PSK, "R6");
        drain();
        d0 = -1;
        for (int i = 0; i < 4; i++) begin
            wait (ext_rise_cnt > 0);
            t0 = ext_rise_cnt;
            wait (ext_rise_cnt != t0);
            t0 = cyc;
            fc = fall_cnt;
            wait (fall_cnt != fc);
            if (d0 < 0) begin
                d0 = cyc - t0;
                chk(d0 <= 8, "R6", "reference-to-fall delay bound", d0, 8);
            end else begin
                chk((cyc - t0) == d0, "R6", "reference-to-fall delay constant", cyc - t0, d0);
            end
        end

        // R5/R6: slave to the receive clock, one count faster.
        src_sel = 2'b10;
        wait_rises(1);
        push_per(100, P_PSK - 1, P_PSK + 1, "R5");
        push_per(8, 191, 191, "R6");
        drain();

        // R8: txclk never stalled.
        chk(max_gap <= P_PSK, "R8", "longest txclk level", max_gap, P_PSK);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule